// File: doc/BRIEF.md
# SDRAM Self-Refresh Sleep Sequencer

This block takes an SDRAM device into self-refresh and brings it back out again. Software controls it with a single go-to-sleep request level and reads a sleep status flag. When the request is raised, the block first waits for any access already in progress to finish. It then closes all banks with a precharge-all command and waits the precharge time. Next it issues the self-refresh command, and clock enable falls in that same cycle. Finally it parks the SDRAM clock at a constant high level, with clock enable held low.

When the request is cleared, the block restarts the SDRAM clock. One cycle later it raises clock enable. It then waits a programmable exit-recovery count before it reports that the device is awake. The status flag stays set through the whole exit sequence. A busy output tells the access controller not to start any new access from the moment the request is seen until the status flag has cleared.

Top module: `sdram_sleep_seq`

## Requirements
- R1: After reset the block is idle. Command is NOP (code 2'b00), clock enable is 1, clock park is 0, status is 0, and busy is 0 while no request is present.
- R2: With no access in progress, a raised request gives a precharge-all command (code 2'b01) in the next cycle. TRP_CYC cycles of NOP follow, then exactly one self-refresh command (code 2'b10).
- R3: Clock enable is 0 in the self-refresh command cycle. From the next cycle, clock park is 1 and clock enable stays 0. The status flag is never 1 before that next cycle.
- R4: A request raised while an access is in progress issues no command until the access input falls. Precharge-all follows in the cycle after it falls.
- R5: A request withdrawn while it is still held behind an access returns the block to idle. No command is issued and busy drops.
- R6: When the request clears during sleep, the next cycle has clock park 0 with clock enable still 0. The cycle after that has clock enable 1. The status flag stays 1 through both cycles.
- R7: The status flag clears max(xrec_i, 8) + 1 cycles after clock enable rises. Any xrec_i value below 8 behaves as 8.
- R8: Busy is 1 whenever the request is set or a sequence is under way. It falls in the same cycle as the status flag at the end of exit.
- R9: While the clock is parked, only NOP commands are issued and the block stays asleep for as long as the request holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req_i | input | 1 | Go-to-sleep request level from the control register |
| acc_busy_i | input | 1 | An SDRAM access is in progress |
| xrec_i | input | XREC_W | Exit-recovery cycle count (floor of 8) |
| cmd_o | output | 2 | SDRAM command: 00 NOP, 01 precharge-all, 10 self-refresh |
| cke_o | output | 1 | SDRAM clock enable level |
| clk_park_o | output | 1 | 1 holds the SDRAM clock pin high |
| sleep_stat_o | output | 1 | Sleep status flag for the register read path |
| seq_busy_o | output | 1 | Blocks new accesses while sleeping or sequencing |

## Verification
The block is driven with four patterns: a request on an idle bus, a request that waits behind an ongoing access, a request withdrawn while it waits, and wake-ups with recovery counts of 3, 9 and 12. The first pattern pins down the exact order of commands and the cycle in which clock enable falls. The waiting pattern shows that the sequence is held until the access input falls, not merely delayed. The withdrawal shows that a held request leaves no command behind. The three recovery values separate the floor of 8 from counts used as given.

// File: rtl/sleep_pkg.sv
package sleep_pkg;
  typedef enum logic [1:0] {
    CMD_NOP  = 2'b00,
    CMD_PALL = 2'b01,
    CMD_SREF = 2'b10
  } sd_cmd_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_HOLD,
    ST_PALL,
    ST_TRP,
    ST_SREF,
    ST_SLEEP,
    ST_WCLK,
    ST_WCKE,
    ST_REC
  } seq_st_e;
endpackage

// File: rtl/sleep_rst_sync.sv
module sleep_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_s = sync_q[1];
endmodule

// File: rtl/sleep_timer.sv
module sleep_timer #(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [TMR_W-1:0] val_i,
  output logic             zero_o
);
  logic [TMR_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = load_i | (cnt_q != '0);

  always_comb begin
    if (load_i) cnt_d = val_i;
    else        cnt_d = cnt_q - TMR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

  // R7: an expired count stays at zero until the next load
  p_tmr_hold_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && cnt_q == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/sleep_ctrl.sv
module sleep_ctrl
  import sleep_pkg::*;
#(
  parameter int TRP_CYC  = 2,
  parameter int XREC_W   = 8,
  parameter int XREC_MIN = 8,
  parameter int TMR_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_req_i,
  input  logic              acc_busy_i,
  input  logic [XREC_W-1:0] xrec_i,
  input  logic              tmr_zero_i,
  output seq_st_e           st_o,
  output logic              tmr_load_o,
  output logic [TMR_W-1:0]  tmr_val_o
);
  seq_st_e          st_q, st_d;
  logic [TMR_W-1:0] rec_len;

  assign rec_len = (xrec_i < XREC_W'(XREC_MIN)) ? TMR_W'(XREC_MIN) : TMR_W'(xrec_i);

  always_comb begin
    st_d       = st_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    case (st_q)
      ST_IDLE:  if (sleep_req_i) st_d = acc_busy_i ? ST_HOLD : ST_PALL;
      ST_HOLD: begin
        if (!sleep_req_i)    st_d = ST_IDLE;
        else if (!acc_busy_i) st_d = ST_PALL;
      end
      ST_PALL: begin
        tmr_load_o = 1'b1;
        tmr_val_o  = TMR_W'(TRP_CYC - 1);
        st_d       = ST_TRP;
      end
      ST_TRP:   if (tmr_zero_i) st_d = ST_SREF;
      ST_SREF:  st_d = ST_SLEEP;
      ST_SLEEP: if (!sleep_req_i) st_d = ST_WCLK;
      ST_WCLK:  st_d = ST_WCKE;
      ST_WCKE: begin
        tmr_load_o = 1'b1;
        tmr_val_o  = rec_len - TMR_W'(1);
        st_d       = ST_REC;
      end
      ST_REC:   if (tmr_zero_i) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign st_o = st_q;

  // R4: a request stays held while the access is still running
  p_hold_acc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HOLD && sleep_req_i && acc_busy_i) |=> (st_q == ST_HOLD));

  // R9: the device stays asleep while the request holds
  p_stay_asleep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SLEEP && sleep_req_i) |=> (st_q == ST_SLEEP));
endmodule

// File: rtl/sleep_pins.sv
module sleep_pins
  import sleep_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  seq_st_e st_i,
  input  logic    sleep_req_i,
  input  logic    acc_busy_i,
  output logic [1:0] cmd_o,
  output logic    cke_o,
  output logic    clk_park_o,
  output logic    sleep_stat_o,
  output logic    seq_busy_o
);
  always_comb begin
    cmd_o        = CMD_NOP;
    cke_o        = 1'b1;
    clk_park_o   = 1'b0;
    sleep_stat_o = 1'b0;
    case (st_i)
      ST_PALL:  cmd_o = CMD_PALL;
      ST_SREF: begin
        cmd_o = CMD_SREF;
        cke_o = 1'b0;
      end
      ST_SLEEP: begin
        cke_o        = 1'b0;
        clk_park_o   = 1'b1;
        sleep_stat_o = 1'b1;
      end
      ST_WCLK: begin
        cke_o        = 1'b0;
        sleep_stat_o = 1'b1;
      end
      ST_WCKE, ST_REC: sleep_stat_o = 1'b1;
      default: ;
    endcase
  end

  assign seq_busy_o = (st_i != ST_IDLE) | sleep_req_i;

  // R3: a parked clock always comes with clock enable low
  p_park_cke_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clk_park_o |-> !cke_o);

  // R2: status rises only right after the self-refresh command
  p_stat_after_sref_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_stat_o) |-> ($past(cmd_o) == CMD_SREF));

  // R6: status clears only with the clock running and enabled
  p_stat_fall_awake_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep_stat_o) |-> (cke_o && !clk_park_o));

  // R8: status always implies busy
  p_busy_cover_stat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_stat_o |-> seq_busy_o);

  // R4: precharge-all never overlaps an access
  p_pall_no_acc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_PALL) |-> !acc_busy_i);

  // R9: parked clock carries only NOP
  p_parked_nop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clk_park_o |-> (cmd_o == CMD_NOP));
endmodule

// File: rtl/sdram_sleep_seq.sv
module sdram_sleep_seq
  import sleep_pkg::*;
#(
  parameter int TRP_CYC  = 2,
  parameter int XREC_W   = 8,
  parameter int XREC_MIN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_req_i,
  input  logic              acc_busy_i,
  input  logic [XREC_W-1:0] xrec_i,
  output logic [1:0]        cmd_o,
  output logic              cke_o,
  output logic              clk_park_o,
  output logic              sleep_stat_o,
  output logic              seq_busy_o
);
  localparam int TRP_W = $clog2(TRP_CYC + 1);
  localparam int TMR_W = (XREC_W > TRP_W) ? XREC_W : TRP_W;

  logic             rst_n_s;
  logic             tmr_load, tmr_zero;
  logic [TMR_W-1:0] tmr_val;
  seq_st_e          st;

  sleep_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  sleep_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  sleep_ctrl #(
    .TRP_CYC (TRP_CYC),
    .XREC_W  (XREC_W),
    .XREC_MIN(XREC_MIN),
    .TMR_W   (TMR_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .sleep_req_i (sleep_req_i),
    .acc_busy_i  (acc_busy_i),
    .xrec_i      (xrec_i),
    .tmr_zero_i  (tmr_zero),
    .st_o        (st),
    .tmr_load_o  (tmr_load),
    .tmr_val_o   (tmr_val)
  );

  sleep_pins u_pins (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .st_i         (st),
    .sleep_req_i  (sleep_req_i),
    .acc_busy_i   (acc_busy_i),
    .cmd_o        (cmd_o),
    .cke_o        (cke_o),
    .clk_park_o   (clk_park_o),
    .sleep_stat_o (sleep_stat_o),
    .seq_busy_o   (seq_busy_o)
  );
endmodule

// File: tb/sdram_sleep_seq_tb.sv
`timescale 1ns/1ps
module sdram_sleep_seq_tb;
  localparam int TRP = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req, acc;
  logic [7:0] xrec;
  logic [1:0] cmd;
  logic       cke, park, stat, busy;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         finished = 1'b0;

  always #10 clk = ~clk;

  sdram_sleep_seq #(.TRP_CYC(TRP), .XREC_W(8), .XREC_MIN(8)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .sleep_req_i  (req),
    .acc_busy_i   (acc),
    .xrec_i       (xrec),
    .cmd_o        (cmd),
    .cke_o        (cke),
    .clk_park_o   (park),
    .sleep_stat_o (stat),
    .seq_busy_o   (busy)
  );

  task automatic step();
    @(posedge clk);
    #5;
  endtask

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic t_reset();
    chk(cmd == 2'b00, "R1", "cmd", cmd, 0);
    chk(cke == 1'b1, "R1", "cke", cke, 1);
    chk(park == 1'b0, "R1", "park", park, 0);
    chk(stat == 1'b0, "R1", "stat", stat, 0);
    chk(busy == 1'b0, "R1", "busy", busy, 0);
  endtask

  task automatic t_enter_idle();
    req = 1'b1; acc = 1'b0;
    #1;
    chk(busy == 1'b1, "R8", "busy on request", busy, 1);
    step();
    chk(cmd == 2'b01, "R2", "precharge-all", cmd, 1);
    for (int i = 0; i < TRP; i++) begin
      step();
      chk(cmd == 2'b00, "R2", "nop in trp", cmd, 0);
    end
    step();
    chk(cmd == 2'b10, "R2", "self-refresh cmd", cmd, 2);
    chk(cke == 1'b0, "R3", "cke low with sref", cke, 0);
    chk(stat == 1'b0, "R3", "no early status", stat, 0);
    step();
    chk(park == 1'b1, "R3", "clock parked", park, 1);
    chk(cke == 1'b0, "R3", "cke low asleep", cke, 0);
    chk(stat == 1'b1, "R3", "status asleep", stat, 1);
    for (int i = 0; i < 5; i++) begin
      step();
      chk(cmd == 2'b00 && park == 1'b1, "R9", "stay asleep nop", {park, cmd}, 4);
    end
  endtask

  task automatic t_exit(input logic [7:0] xv, input int exp_n);
    int n;
    xrec = xv; req = 1'b0;
    step();
    chk(park == 1'b0, "R6", "clock restarted", park, 0);
    chk(cke == 1'b0, "R6", "cke still low", cke, 0);
    chk(stat == 1'b1, "R6", "status in wclk", stat, 1);
    step();
    chk(cke == 1'b1, "R6", "cke raised", cke, 1);
    chk(stat == 1'b1, "R6", "status in wcke", stat, 1);
    n = 0;
    for (int i = 1; i <= 40; i++) begin
      step();
      if (stat == 1'b0) begin
        n = i;
        break;
      end
      if (busy != 1'b1) chk(1'b0, "R8", "busy during recovery", busy, 1);
    end
    chk(n == exp_n, "R7", "recovery length", n, exp_n);
    chk(busy == 1'b0, "R8", "busy falls with status", busy, 0);
    chk(cmd == 2'b00 && cke == 1'b1, "R6", "awake pins", {cke, cmd}, 4);
  endtask

  task automatic t_held();
    acc = 1'b1; req = 1'b1;
    for (int i = 0; i < 3; i++) begin
      step();
      chk(cmd == 2'b00, "R4", "no cmd during access", cmd, 0);
      chk(busy == 1'b1, "R4", "busy while held", busy, 1);
    end
    acc = 1'b0;
    step();
    chk(cmd == 2'b01, "R4", "pall after access", cmd, 1);
    for (int i = 0; i < TRP; i++) step();
    step();
    chk(cmd == 2'b10, "R4", "sref after held entry", cmd, 2);
    step();
    chk(stat == 1'b1, "R4", "asleep after held entry", stat, 1);
  endtask

  task automatic t_withdraw();
    acc = 1'b1; req = 1'b1;
    step();
    step();
    req = 1'b0;
    step();
    chk(busy == 1'b0, "R5", "busy dropped", busy, 0);
    chk(cmd == 2'b00, "R5", "no cmd after withdraw", cmd, 0);
    acc = 1'b0;
    for (int i = 0; i < 3; i++) begin
      step();
      chk(cmd == 2'b00 && stat == 1'b0, "R5", "still idle", {stat, cmd}, 0);
    end
  endtask

  initial begin
    rst_n = 1'b0; req = 1'b0; acc = 1'b0; xrec = 8'd3;
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;
    repeat (3) step();
    t_reset();
    t_enter_idle();
    t_exit(8'd3, 9);
    t_held();
    t_exit(8'd12, 13);
    t_withdraw();
    t_enter_idle();
    t_exit(8'd9, 10);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule